// File: doc/BRIEF.md
# Subaddressed Control Register Slave for a TV Sound Processor

This block is a two-wire serial slave that keeps the eight 8-bit control registers of a television stereo sound processor and returns one status byte to the bus master. A write transfer opens with the address byte 0x84 and then carries any number of subaddress/data byte pairs. Each data byte needs its own subaddress in front of it, and there is no auto-increment. Each pair is acknowledged. A register output changes only after its data byte has been fully acknowledged.

A read transfer opens with 0x85 after a fresh start condition. The slave then shifts out a status byte. That byte holds the identification decoder result and a sticky clip flag, and a completed read clears the clip flag. The bus lines are oversampled by the system clock through synchronizers. SDA is driven through an open-drain enable. The register contents leave the block as parallel buses that the audio path consumes directly.

Top module: `tvsnd_ctl_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1000010. First byte 0x84 opens a write, 0x85 opens a read. Any other address gets no ACK, and the bytes that follow it change nothing until the next start.
- R2: In a write, the bytes after the address alternate strictly: subaddress, data, subaddress, data. Any mix of registers may be written in one transfer.
- R3: After a subaddress and its data byte, the next byte is always taken as a new subaddress, never as more data for the same register.
- R4: The slave pulls SDA low in the ninth clock of the address byte and of every written byte. At all other times in a write it leaves SDA released. SDA output changes only while SCL is low.
- R5: Only bits 2:0 of a subaddress select the register, and bits 7:3 are ignored. The mapping is: 0 switch II, 1 left speaker volume, 2 right speaker volume, 3 headphone volume, 4 input volume, 5 tone, 6 crosstalk, 7 switch I.
- R6: The status byte is {stereo, dual, 3'b000, clip, 2'b00}. Bit 7 is the stereo flag, bit 6 the dual flag and bit 2 the clip flag. The flag pair reads 00 for mono, 10 for stereo, 01 for dual and 11 for inhibited.
- R7: A clip pulse sets the clip flag. The flag holds until a status byte read completes, which clears it. A pulse that arrives after the byte was captured is kept for the next read.
- R8: After reset, registers 0, 3, 5, 6 and 7 hold 0x01 and registers 1, 2 and 4 hold 0x00. This leaves all mute enables at 0 (muted) and all channel selects at 0 (sound 1). SDA is released.
- R9: A register changes only after the falling SCL edge that ends the ACK of its data byte. A new start condition makes the next written byte a subaddress again.
- R10: In a read, a master ACK makes the slave send a freshly captured status byte. A master NACK makes the slave release SDA until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| id_stereo_i | input | 1 | Identification decoder reports stereo |
| id_dual_i | input | 1 | Identification decoder reports dual sound |
| clip_pulse_i | input | 1 | One-cycle pulse when the speaker path clips |
| sw2_o | output | 8 | Switch register II (subaddress 0) |
| vol_left_o | output | 8 | Left speaker volume (subaddress 1) |
| vol_right_o | output | 8 | Right speaker volume (subaddress 2) |
| vol_phone_o | output | 8 | Headphone volume (subaddress 3) |
| vol_in_o | output | 8 | Input volume and scart selection (subaddress 4) |
| tone_o | output | 8 | Treble/bass (subaddress 5) |
| xtalk_o | output | 8 | Crosstalk adjustment (subaddress 6) |
| sw1_o | output | 8 | Switch register I (subaddress 7) |

## Verification
A stuck or misaligned subaddress/data phase lands the wrong value in the wrong register bus. This shows on the parallel outputs within a few clocks of the ACK that ends the byte. A bad bit counter or a bad bus state appears on the wire one SCL period later, as a missing ACK or a wrongly timed one. A clip flag that is cleared at the wrong moment, or captured at the wrong moment, changes bit 2 of the next status byte read back. The bench therefore writes every subaddress with varied upper bits and reads back every flag code. It also runs the clip sequence before, during and after reads.

// File: rtl/tvsnd_ctl_pkg.sv
package tvsnd_ctl_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SUB_W  = 3;
  localparam int unsigned NREG   = 1 << SUB_W;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [6:0] DEV_ADDR_DEFAULT = 7'b1000010;

  // register index map (decoded by the audio path)
  localparam int unsigned IDX_SW2   = 0;
  localparam int unsigned IDX_VOL_L = 1;
  localparam int unsigned IDX_VOL_R = 2;
  localparam int unsigned IDX_PHONE = 3;
  localparam int unsigned IDX_VOL_I = 4;
  localparam int unsigned IDX_TONE  = 5;
  localparam int unsigned IDX_XTALK = 6;
  localparam int unsigned IDX_SW1   = 7;

  // status byte positions
  localparam int unsigned ST_STEREO_BIT = 7;
  localparam int unsigned ST_DUAL_BIT   = 6;
  localparam int unsigned ST_CLIP_BIT   = 2;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_ADDR_ACK,
    BS_WR,
    BS_WR_ACK,
    BS_RD,
    BS_RD_ACK,
    BS_SKIP
  } bus_state_t;

  function automatic logic [BYTE_W-1:0] reg_reset_value(input int unsigned idx);
    logic [BYTE_W-1:0] v;
    case (idx)
      IDX_VOL_L, IDX_VOL_R, IDX_VOL_I: v = 8'h00;
      default:                         v = 8'h01;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tvsnd_bus_sync.sv
module tvsnd_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic rst_n_o,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [1:0]        rst_chain_q;
  logic [STAGES-1:0] scl_chain_q;
  logic [STAGES-1:0] sda_chain_q;
  logic              scl_prev_q;
  logic              sda_prev_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_chain_q <= 2'b00;
    else          rst_chain_q <= {rst_chain_q[0], 1'b1};
  end
  assign rst_n_o = rst_chain_q[1];

  always_ff @(posedge clk or negedge rst_n_o) begin
    if (!rst_n_o) begin
      scl_chain_q <= '1;
      sda_chain_q <= '1;
      scl_prev_q  <= 1'b1;
      sda_prev_q  <= 1'b1;
    end else begin
      scl_chain_q <= {scl_chain_q[STAGES-2:0], scl_i};
      sda_chain_q <= {sda_chain_q[STAGES-2:0], sda_i};
      scl_prev_q  <= scl_chain_q[STAGES-1];
      sda_prev_q  <= sda_chain_q[STAGES-1];
    end
  end

  assign scl_o      = scl_chain_q[STAGES-1];
  assign sda_o      = sda_chain_q[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/tvsnd_byte_engine.sv
module tvsnd_byte_engine
  import tvsnd_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = DEV_ADDR_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              rd_load_o,
  output logic              rd_done_o
);

  bus_state_t        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] rx_q, rx_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              oe_q, oe_n;
  logic              rw_q, rw_n;
  logic              mack_q, mack_n;
  logic              wv_q, wv_n;

  localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LASTB = CNT_W'(BYTE_W - 1);

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    oe_n      = oe_q;
    rw_n      = rw_q;
    mack_n    = mack_q;
    wv_n      = 1'b0;
    rd_load_o = 1'b0;
    rd_done_o = 1'b0;
    if (start_i) begin
      state_n = BS_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
    end else if (stop_i) begin
      state_n = BS_IDLE;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        BS_ADDR, BS_WR: begin
          if (scl_rise_i) begin
            rx_n  = {rx_q[BYTE_W-2:0], sda_s_i};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == FULL) begin
            if (state_q == BS_WR) begin
              oe_n    = 1'b1;
              state_n = BS_WR_ACK;
            end else if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
              oe_n    = 1'b1;
              rw_n    = rx_q[0];
              state_n = BS_ADDR_ACK;
              if (rx_q[0]) begin
                rd_load_o = 1'b1;
                tx_n      = status_i;
              end
            end else begin
              state_n = BS_SKIP;
            end
          end
        end
        BS_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_n = '0;
            if (rw_q) begin
              state_n = BS_RD;
              oe_n    = ~tx_q[BYTE_W-1];
            end else begin
              state_n = BS_WR;
              oe_n    = 1'b0;
            end
          end
        end
        BS_WR_ACK: begin
          if (scl_fall_i) begin
            oe_n    = 1'b0;
            cnt_n   = '0;
            wv_n    = 1'b1;
            state_n = BS_WR;
          end
        end
        BS_RD: begin
          if (scl_fall_i) begin
            if (cnt_q == LASTB) begin
              oe_n    = 1'b0;
              state_n = BS_RD_ACK;
            end else begin
              tx_n  = {tx_q[BYTE_W-2:0], 1'b0};
              cnt_n = cnt_q + 1'b1;
              oe_n  = ~tx_q[BYTE_W-2];
            end
          end
        end
        BS_RD_ACK: begin
          if (scl_rise_i) begin
            mack_n = ~sda_s_i;
          end else if (scl_fall_i) begin
            rd_done_o = 1'b1;
            if (mack_q) begin
              rd_load_o = 1'b1;
              tx_n      = status_i;
              oe_n      = ~status_i[BYTE_W-1];
              cnt_n     = '0;
              state_n   = BS_RD;
            end else begin
              state_n = BS_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      wv_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      oe_q    <= oe_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      wv_q    <= wv_n;
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_valid_o = wv_q;
  assign wr_byte_o  = rx_q;

  // R4: the slave only moves SDA while the synchronized SCL is low
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s_i);

  // R4: SDA is pulled only in ACK slots or while shifting read data
  a_r4_drive_in_slots: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (state_q inside {BS_ADDR_ACK, BS_WR_ACK, BS_RD}));

  // R10: after a NACK, or with a foreign address, SDA stays released
  a_r10_skip_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BS_SKIP) |-> !oe_q);

endmodule

// File: rtl/tvsnd_status_src.sv
module tvsnd_status_src
  import tvsnd_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_stereo_i,
  input  logic              id_dual_i,
  input  logic              clip_pulse_i,
  input  logic              rd_load_i,
  input  logic              rd_done_i,
  output logic [BYTE_W-1:0] status_o
);

  logic clip_q, clip_n;
  logic fresh_q, fresh_n;
  logic clip_vis;

  // clip value as it will stand after this cycle's completed read, if any
  always_comb begin
    clip_vis = rd_done_i ? (fresh_q | clip_pulse_i) : (clip_q | clip_pulse_i);
    clip_n   = clip_vis;
    fresh_n  = rd_load_i ? 1'b0 : (fresh_q | clip_pulse_i);
    status_o = '0;
    status_o[ST_STEREO_BIT] = id_stereo_i;
    status_o[ST_DUAL_BIT]   = id_dual_i;
    status_o[ST_CLIP_BIT]   = clip_vis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clip_q  <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      clip_q  <= clip_n;
      fresh_q <= fresh_n;
    end
  end

  // R7: a clip pulse is always visible in the following cycle
  a_r7_clip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    clip_pulse_i |=> clip_q);

  // R7: the flag only drops at a completed read
  a_r7_clip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_q && !rd_done_i) |=> clip_q);

endmodule

// File: rtl/tvsnd_reg_bank.sv
module tvsnd_reg_bank
  import tvsnd_ctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   wr_valid_i,
  input  logic [BYTE_W-1:0]      wr_byte_i,
  output logic [NREG*BYTE_W-1:0] regs_o
);

  logic             data_phase_q, data_phase_n;
  logic [SUB_W-1:0] sub_q, sub_n;
  logic [NREG-1:0]  wr_en;

  always_comb begin
    data_phase_n = data_phase_q;
    sub_n        = sub_q;
    wr_en        = '0;
    if (start_i) begin
      data_phase_n = 1'b0;
    end else if (wr_valid_i) begin
      data_phase_n = ~data_phase_q;
      if (data_phase_q) wr_en = NREG'(1) << sub_q;
      else              sub_n = wr_byte_i[SUB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_phase_q <= 1'b0;
      sub_q        <= '0;
    end else begin
      data_phase_q <= data_phase_n;
      sub_q        <= sub_n;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        val_q <= reg_reset_value(g);
      else if (wr_en[g]) val_q <= wr_byte_i;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = val_q;
  end

  // R9: no register moves without an acknowledged byte
  a_r9_hold_without_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_i |=> $stable(regs_o));

  // R2: every acknowledged byte flips between subaddress and data
  a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !start_i) |=> (data_phase_q != $past(data_phase_q)));

endmodule

// File: rtl/tvsnd_ctl_slave.sv
module tvsnd_ctl_slave
  import tvsnd_ctl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = DEV_ADDR_DEFAULT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              id_stereo_i,
  input  logic              id_dual_i,
  input  logic              clip_pulse_i,
  output logic [BYTE_W-1:0] sw2_o,
  output logic [BYTE_W-1:0] vol_left_o,
  output logic [BYTE_W-1:0] vol_right_o,
  output logic [BYTE_W-1:0] vol_phone_o,
  output logic [BYTE_W-1:0] vol_in_o,
  output logic [BYTE_W-1:0] tone_o,
  output logic [BYTE_W-1:0] xtalk_o,
  output logic [BYTE_W-1:0] sw1_o
);

  logic                   rst_n_s;
  logic                   scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [BYTE_W-1:0]      status_byte;
  logic                   wr_valid;
  logic [BYTE_W-1:0]      wr_byte;
  logic                   rd_load, rd_done;
  logic [NREG*BYTE_W-1:0] regs;

  tvsnd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n_i    (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .rst_n_o    (rst_n_s),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  tvsnd_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .status_i   (status_byte),
    .sda_oe_o   (sda_oe_o),
    .wr_valid_o (wr_valid),
    .wr_byte_o  (wr_byte),
    .rd_load_o  (rd_load),
    .rd_done_o  (rd_done)
  );

  tvsnd_status_src u_status (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .id_stereo_i  (id_stereo_i),
    .id_dual_i    (id_dual_i),
    .clip_pulse_i (clip_pulse_i),
    .rd_load_i    (rd_load),
    .rd_done_i    (rd_done),
    .status_o     (status_byte)
  );

  tvsnd_reg_bank u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_c),
    .wr_valid_i (wr_valid),
    .wr_byte_i  (wr_byte),
    .regs_o     (regs)
  );

  assign sw2_o       = regs[IDX_SW2*BYTE_W   +: BYTE_W];
  assign vol_left_o  = regs[IDX_VOL_L*BYTE_W +: BYTE_W];
  assign vol_right_o = regs[IDX_VOL_R*BYTE_W +: BYTE_W];
  assign vol_phone_o = regs[IDX_PHONE*BYTE_W +: BYTE_W];
  assign vol_in_o    = regs[IDX_VOL_I*BYTE_W +: BYTE_W];
  assign tone_o      = regs[IDX_TONE*BYTE_W  +: BYTE_W];
  assign xtalk_o     = regs[IDX_XTALK*BYTE_W +: BYTE_W];
  assign sw1_o       = regs[IDX_SW1*BYTE_W   +: BYTE_W];

endmodule

// File: tb/test_tvsnd_ctl_slave.sv
module test_tvsnd_ctl_slave;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic id_st = 1'b0;
  logic id_du = 1'b0;
  logic clip_p = 1'b0;
  logic [7:0] r_sw2, r_vl, r_vr, r_ph, r_vi, r_tone, r_xt, r_sw1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_reg [8];

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  tvsnd_ctl_slave i_tvsnd_ctl_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (m_scl),
    .sda_i        (sda_line),
    .sda_oe_o     (sda_oe),
    .id_stereo_i  (id_st),
    .id_dual_i    (id_du),
    .clip_pulse_i (clip_p),
    .sw2_o        (r_sw2),
    .vol_left_o   (r_vl),
    .vol_right_o  (r_vr),
    .vol_phone_o  (r_ph),
    .vol_in_o     (r_vi),
    .tone_o       (r_tone),
    .xtalk_o      (r_xt),
    .sw1_o        (r_sw1)
  );

  function automatic logic [7:0] port_reg(input int idx);
    case (idx)
      0: return r_sw2;
      1: return r_vl;
      2: return r_vr;
      3: return r_ph;
      4: return r_vi;
      5: return r_tone;
      6: return r_xt;
      default: return r_sw1;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", what, act, exp);
    end
  endtask

  task automatic check_all_regs(input string what);
    for (int i = 0; i < 8; i++) check($sformatf("%s reg%0d", what, i), port_reg(i), exp_reg[i]);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = (sda_line == 1'b0);
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    send_bit(~mack);
  endtask

  task automatic pulse_clip();
    clip_p = 1'b1; tick(1);
    clip_p = 1'b0; tick(1);
  endtask

  // one read transfer with NACK; returns the status byte
  task automatic read_status(output logic [7:0] b, input string what);
    logic ack;
    bus_start();
    wr_byte(8'h85, ack);
    check({what, " R1 read address ACK"}, {7'd0, ack}, 8'h01);
    rd_byte(b, 1'b0);
    tick(Q);
    check({what, " R10 SDA released after NACK"}, {7'd0, sda_oe}, 8'h00);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] b, b2, v;
    for (int i = 0; i < 8; i++) exp_reg[i] = (i == 1 || i == 2 || i == 4) ? 8'h00 : 8'h01;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R8 reset values
    check_all_regs("R8 reset");
    check("R8 SDA released at reset", {7'd0, sda_oe}, 8'h00);

    // R2 R5 sweep: all subaddresses in one transfer, upper bits varied
    bus_start();
    wr_byte(8'h84, ack);
    check("R1 write address ACK", {7'd0, ack}, 8'h01);
    for (int s = 0; s < 8; s++) begin
      v = 8'((s * 53 + 23) & 255);
      wr_byte(8'(((s * 3 + 1) << 3) | s), ack);
      check($sformatf("R4 ACK subaddress %0d", s), {7'd0, ack}, 8'h01);
      wr_byte(v, ack);
      check($sformatf("R4 ACK data %0d", s), {7'd0, ack}, 8'h01);
      exp_reg[s] = v;
    end
    bus_stop();
    check_all_regs("R2 R5 sweep");

    // R5 reverse order, one pair per transfer, upper bits all ones
    for (int s = 7; s >= 0; s--) begin
      v = ~8'((s * 53 + 23) & 255);
      bus_start();
      wr_byte(8'h84, ack);
      wr_byte(8'hF8 | 8'(s), ack);
      wr_byte(v, ack);
      bus_stop();
      exp_reg[s] = v;
    end
    check_all_regs("R5 reverse sweep");

    // R3: sub 03, 08, 09, 0A -> phone=08, then 09 is a subaddress (left), 0A its data
    bus_start();
    wr_byte(8'h84, ack);
    wr_byte(8'h03, ack);
    wr_byte(8'h08, ack);
    wr_byte(8'h09, ack);
    wr_byte(8'h0A, ack);
    bus_stop();
    exp_reg[3] = 8'h08;
    exp_reg[1] = 8'h0A;
    check_all_regs("R3 data-data sequence");

    // R1: foreign address gets no ACK and changes nothing
    bus_start();
    wr_byte(8'h86, ack);
    check("R1 foreign address no ACK", {7'd0, ack}, 8'h00);
    wr_byte(8'h01, ack);
    check("R1 byte after foreign address no ACK", {7'd0, ack}, 8'h00);
    wr_byte(8'h55, ack);
    bus_stop();
    check_all_regs("R1 foreign address ignored");

    // R9: a new start resets the alternation
    bus_start();
    wr_byte(8'h84, ack);
    wr_byte(8'h02, ack);
    bus_start();
    wr_byte(8'h84, ack);
    wr_byte(8'h05, ack);
    wr_byte(8'h66, ack);
    bus_stop();
    exp_reg[5] = 8'h66;
    check_all_regs("R9 restart makes subaddress");

    // R9: register changes only after the ACK clock ends
    bus_start();
    wr_byte(8'h84, ack);
    wr_byte(8'h02, ack);
    for (int i = 7; i >= 0; i--) send_bit(1'(8'hC3 >> i));
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    check("R9 ACK slot driven", {7'd0, sda_oe}, 8'h01);
    check("R9 right volume before ACK end", r_vr, exp_reg[2]);
    tick(Q);
    m_scl = 1'b0; tick(Q);
    exp_reg[2] = 8'hC3;
    check("R9 right volume after ACK end", r_vr, 8'hC3);
    bus_stop();

    // R6: all flag codes, clip clear
    for (int c = 0; c < 4; c++) begin
      id_st = c[1];
      id_du = c[0];
      read_status(b, "R6");
      check($sformatf("R6 status code %0d", c), b, 8'({c[1], c[0], 6'b0}));
    end
    id_st = 1'b1; id_du = 1'b0;

    // R7: pulse sets, completed read clears
    pulse_clip();
    read_status(b, "R7");
    check("R7 clip visible", b, 8'h84);
    read_status(b, "R7");
    check("R7 clip cleared by read", b, 8'h80);

    // R7: pulse after capture is kept for the next read
    bus_start();
    wr_byte(8'h85, ack);
    pulse_clip();
    rd_byte(b, 1'b0);
    bus_stop();
    check("R7 byte captured before pulse", b, 8'h80);
    read_status(b, "R7");
    check("R7 late pulse kept", b, 8'h84);
    read_status(b, "R7");
    check("R7 late pulse cleared", b, 8'h80);

    // R10: master ACK yields a fresh status byte
    id_st = 1'b0; id_du = 1'b1;
    pulse_clip();
    bus_start();
    wr_byte(8'h85, ack);
    rd_byte(b, 1'b1);
    rd_byte(b2, 1'b0);
    tick(Q);
    check("R10 SDA released after NACK", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    check("R10 first byte", b, 8'h44);
    check("R10 second byte recaptured", b2, 8'h40);
    check_all_regs("R6 reads leave registers");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule